// File: doc/BRIEF.md
# Operand Locator for Two-Byte Register/Memory Instruction Forms

This block reads the leading byte of an instruction and the operand-form byte that follows it. It works out where the two operands of the instruction are found. The leading byte supplies the direction and width flags. The operand-form byte is split into a 2-bit mode, a 3-bit register code and a 3-bit register-or-memory code.

When the second operand is held in a register, the block reports which register file entry and which part of it is meant: the low byte, the high byte or the whole word. When the second operand is in memory, the block reports how many displacement bytes follow the operand-form byte. It also sums the base register, the index register and the displacement into a 16-bit effective address. Segment offsets, memory access and execution are handled elsewhere.

All results are registered one clock after a `valid_i` strobe. The outputs hold their values while `valid_i` is low. A fetch unit can use `disp_len_o` to step past the displacement to any immediate data.

Top module: `modrm_decoder`

## Requirements
- R1: While `rst_ni` is low, every output reads zero.
- R2: Each output takes its new value at the first rising clock edge that samples `valid_i` high. `valid_o` is high in exactly the cycle after such an edge. While `valid_i` is low, all data outputs hold their values.
- R3: Fields are taken from fixed bit positions. In `modrm_i`, bits [7:6] are the mode, bits [5:3] are the register code and bits [2:0] are the register-or-memory code. In `opc_i`, bit 1 is the direction flag, bit 0 is the width flag, and bits [7:2] are returned unchanged on `opcode_o`.
- R4: `reg_is_dst_o` equals the direction flag: 1 means the register-code operand is written, 0 means it is read.
- R5: With width flag 1, a register code maps to `idx` equal to the code and `part` = 2'b11 (whole word; codes 0..7 name AX, CX, DX, BX, SP, BP, SI, DI).
- R6: With width flag 0, codes 0..3 map to `idx` equal to the code with `part` = 2'b01 (low byte: AL, CL, DL, BL). Codes 4..7 map to `idx` equal to the code minus 4 with `part` = 2'b10 (high byte: AH, CH, DH, BH).
- R7: Mode 2'b11 is the register-register form. `rm_is_mem_o` is 0, the register-or-memory code is mapped by R5/R6, `disp_len_o` is 0 and `ea_o` is 0.
- R8: Modes 2'b00, 2'b01 and 2'b10 set `rm_is_mem_o` to 1, `rm_idx_o` to 0 and `rm_part_o` to 2'b00.
- R9: `disp_len_o` depends on the mode. Mode 2'b00 gives 0, except that register-or-memory code 3'b110 gives 2. Mode 2'b01 gives 1 and mode 2'b10 gives 2.
- R10: In memory modes, the register-or-memory code picks the base and index as follows: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. The one exception is R12.
- R11: Mode 2'b01 adds `disp_lo_i` sign-extended to 16 bits. Mode 2'b10 adds {`disp_hi_i`,`disp_lo_i`}. Mode 2'b00 adds nothing. The sum wraps modulo 2^16.
- R12: Mode 2'b00 with code 3'b110 gives `ea_o` = {`disp_hi_i`,`disp_lo_i`}, with no register term added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction bytes present this cycle |
| opc_i | input | 8 | Leading instruction byte |
| modrm_i | input | 8 | Operand-form byte |
| disp_lo_i | input | 8 | First displacement byte |
| disp_hi_i | input | 8 | Second displacement byte |
| bx_i | input | 16 | Current BX value |
| bp_i | input | 16 | Current BP value |
| si_i | input | 16 | Current SI value |
| di_i | input | 16 | Current DI value |
| valid_o | output | 1 | Results below are fresh |
| opcode_o | output | 6 | Opcode field of the leading byte |
| reg_is_dst_o | output | 1 | Register-code operand is the destination |
| reg_idx_o | output | 3 | Register file entry of the register-code operand |
| reg_part_o | output | 2 | Part of that entry: 01 low, 10 high, 11 word |
| rm_is_mem_o | output | 1 | Second operand lives in memory |
| rm_idx_o | output | 3 | Register file entry of the second operand (register form) |
| rm_part_o | output | 2 | Part of that entry; 00 in memory form |
| disp_len_o | output | 2 | Displacement bytes to consume (0, 1 or 2) |
| ea_o | output | 16 | Effective address in memory form, else 0 |

## Verification
The hardest case to reach from the ports is an address sum that wraps past 2^16 together with a negative one-byte displacement. The direct-address code under mode 0 must also be told apart from the BP-based code under modes 1 and 2. To get there, the bench sweeps every value of the operand-form byte against all four direction/width combinations. For each vector it derives the register and displacement values from the vector number, so values near 16'hFFFF and displacement bytes with bit 7 set recur throughout the sweep. A final step changes every input while `valid_i` is low, to show that the outputs hold.

// File: rtl/modrm_pkg.sv
package modrm_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [1:0] {
    PART_NONE = 2'b00,
    PART_LO   = 2'b01,
    PART_HI   = 2'b10,
    PART_WORD = 2'b11
  } reg_part_e;

  typedef struct packed {
    logic [CODE_W-1:0] idx;
    reg_part_e         part;
  } reg_sel_t;

  localparam logic [MODE_W-1:0] MODE_NODISP = 2'b00;
  localparam logic [MODE_W-1:0] MODE_DISP8  = 2'b01;
  localparam logic [MODE_W-1:0] MODE_DISP16 = 2'b10;
  localparam logic [MODE_W-1:0] MODE_REG    = 2'b11;
  localparam logic [CODE_W-1:0] RM_DIRECT   = 3'b110;
endpackage

// File: rtl/modrm_field_split.sv
module modrm_field_split
  import modrm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0]        opc_i,
  input  logic [BYTE_W-1:0]        modrm_i,
  output logic [BYTE_W-3:0]        opcode_o,
  output logic                     dir_o,
  output logic                     wide_o,
  output logic [MODE_W-1:0]        mode_o,
  output logic [CODE_W-1:0]        reg_code_o,
  output logic [CODE_W-1:0]        rm_code_o,
  output logic                     is_mem_o,
  output logic                     is_direct_o,
  output logic [1:0]               disp_len_o
);
  assign opcode_o   = opc_i[BYTE_W-1:2];
  assign dir_o      = opc_i[1];
  assign wide_o     = opc_i[0];
  assign mode_o     = modrm_i[BYTE_W-1 -: MODE_W];
  assign reg_code_o = modrm_i[2*CODE_W-1 -: CODE_W];
  assign rm_code_o  = modrm_i[CODE_W-1:0];

  assign is_mem_o    = (mode_o != MODE_REG);
  assign is_direct_o = (mode_o == MODE_NODISP) && (rm_code_o == RM_DIRECT);

  always_comb begin
    unique case (mode_o)
      MODE_DISP8:  disp_len_o = 2'd1;
      MODE_DISP16: disp_len_o = 2'd2;
      MODE_NODISP: disp_len_o = is_direct_o ? 2'd2 : 2'd0;
      default:     disp_len_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/modrm_reg_map.sv
module modrm_reg_map
  import modrm_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              wide_i,
  input  logic              en_i,
  output reg_sel_t          sel_o
);
  localparam int unsigned HALF_BIT = CODE_W - 1;

  always_comb begin
    sel_o = '{idx: '0, part: PART_NONE};
    if (en_i) begin
      if (wide_i) begin
        sel_o.idx  = code_i;
        sel_o.part = PART_WORD;
      end else begin
        // upper code half names the high byte of the lower four registers
        sel_o.idx  = {1'b0, code_i[HALF_BIT-1:0]};
        sel_o.part = code_i[HALF_BIT] ? PART_HI : PART_LO;
      end
    end
  end
endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc
  import modrm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CODE_W-1:0] rm_code_i,
  input  logic              is_mem_i,
  input  logic              is_direct_i,
  input  logic [BYTE_W-1:0] disp_lo_i,
  input  logic [BYTE_W-1:0] disp_hi_i,
  input  logic [ADDR_W-1:0] bx_i,
  input  logic [ADDR_W-1:0] bp_i,
  input  logic [ADDR_W-1:0] si_i,
  input  logic [ADDR_W-1:0] di_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] base_v, index_v, disp_v;
  logic [ADDR_W-1:0] disp_sext, disp_full;

  assign disp_sext = {{(ADDR_W-BYTE_W){disp_lo_i[BYTE_W-1]}}, disp_lo_i};
  assign disp_full = {disp_hi_i, disp_lo_i};

  always_comb begin
    base_v  = '0;
    index_v = '0;
    unique case (rm_code_i)
      3'd0: begin base_v = bx_i; index_v = si_i; end
      3'd1: begin base_v = bx_i; index_v = di_i; end
      3'd2: begin base_v = bp_i; index_v = si_i; end
      3'd3: begin base_v = bp_i; index_v = di_i; end
      3'd4: index_v = si_i;
      3'd5: index_v = di_i;
      3'd6: base_v  = is_direct_i ? '0 : bp_i;
      default: base_v = bx_i;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      MODE_DISP8:  disp_v = disp_sext;
      MODE_DISP16: disp_v = disp_full;
      MODE_NODISP: disp_v = is_direct_i ? disp_full : '0;
      default:     disp_v = '0;
    endcase
  end

  // modulo 2^ADDR_W by truncation
  assign ea_o = is_mem_i ? (base_v + index_v + disp_v) : '0;
endmodule

// File: rtl/modrm_decoder.sv
module modrm_decoder
  import modrm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] opc_i,
  input  logic [BYTE_W-1:0] modrm_i,
  input  logic [BYTE_W-1:0] disp_lo_i,
  input  logic [BYTE_W-1:0] disp_hi_i,
  input  logic [ADDR_W-1:0] bx_i,
  input  logic [ADDR_W-1:0] bp_i,
  input  logic [ADDR_W-1:0] si_i,
  input  logic [ADDR_W-1:0] di_i,
  output logic              valid_o,
  output logic [BYTE_W-3:0] opcode_o,
  output logic              reg_is_dst_o,
  output logic [CODE_W-1:0] reg_idx_o,
  output logic [1:0]        reg_part_o,
  output logic              rm_is_mem_o,
  output logic [CODE_W-1:0] rm_idx_o,
  output logic [1:0]        rm_part_o,
  output logic [1:0]        disp_len_o,
  output logic [ADDR_W-1:0] ea_o
);
  logic [BYTE_W-3:0] opcode_c;
  logic              dir_c, wide_c, is_mem_c, is_direct_c;
  logic [MODE_W-1:0] mode_c;
  logic [CODE_W-1:0] reg_code_c, rm_code_c;
  logic [1:0]        disp_len_c;
  logic [ADDR_W-1:0] ea_c;
  reg_sel_t          reg_sel_c, rm_sel_c;

  modrm_field_split #(.BYTE_W(BYTE_W)) u_split (
    .opc_i       (opc_i),
    .modrm_i     (modrm_i),
    .opcode_o    (opcode_c),
    .dir_o       (dir_c),
    .wide_o      (wide_c),
    .mode_o      (mode_c),
    .reg_code_o  (reg_code_c),
    .rm_code_o   (rm_code_c),
    .is_mem_o    (is_mem_c),
    .is_direct_o (is_direct_c),
    .disp_len_o  (disp_len_c)
  );

  modrm_reg_map u_reg_map (
    .code_i (reg_code_c),
    .wide_i (wide_c),
    .en_i   (1'b1),
    .sel_o  (reg_sel_c)
  );

  modrm_reg_map u_rm_map (
    .code_i (rm_code_c),
    .wide_i (wide_c),
    .en_i   (!is_mem_c),
    .sel_o  (rm_sel_c)
  );

  modrm_ea_calc #(.BYTE_W(BYTE_W)) u_ea (
    .mode_i      (mode_c),
    .rm_code_i   (rm_code_c),
    .is_mem_i    (is_mem_c),
    .is_direct_i (is_direct_c),
    .disp_lo_i   (disp_lo_i),
    .disp_hi_i   (disp_hi_i),
    .bx_i        (bx_i),
    .bp_i        (bp_i),
    .si_i        (si_i),
    .di_i        (di_i),
    .ea_o        (ea_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_o     <= '0;
      reg_is_dst_o <= 1'b0;
      reg_idx_o    <= '0;
      reg_part_o   <= '0;
      rm_is_mem_o  <= 1'b0;
      rm_idx_o     <= '0;
      rm_part_o    <= '0;
      disp_len_o   <= '0;
      ea_o         <= '0;
    end else if (valid_i) begin
      opcode_o     <= opcode_c;
      reg_is_dst_o <= dir_c;
      reg_idx_o    <= reg_sel_c.idx;
      reg_part_o   <= reg_sel_c.part;
      rm_is_mem_o  <= is_mem_c;
      rm_idx_o     <= rm_sel_c.idx;
      rm_part_o    <= rm_sel_c.part;
      disp_len_o   <= disp_len_c;
      ea_o         <= ea_c;
    end
  end

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ea_o) && $stable(reg_idx_o) && $stable(rm_part_o)
                  && $stable(disp_len_o)));
  a_r4_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (reg_is_dst_o == $past(opc_i[1])));
  a_r5_word_part: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opc_i[0]) |=> (reg_part_o == 2'b11));
  a_r7_reg_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rm_is_mem_o) |-> (ea_o == '0 && disp_len_o == 2'd0 && rm_part_o != 2'b00));
  a_r8_mem_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rm_is_mem_o) |-> (rm_part_o == 2'b00 && rm_idx_o == '0));
  a_r9_disp8_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == 2'b01) |=> (disp_len_o == 2'd1));
endmodule

// File: tb/modrm_decoder_tb.sv
module modrm_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opc_i = '0, modrm_i = '0, disp_lo_i = '0, disp_hi_i = '0;
  logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
  logic        valid_o, reg_is_dst_o, rm_is_mem_o;
  logic [5:0]  opcode_o;
  logic [2:0]  reg_idx_o, rm_idx_o;
  logic [1:0]  reg_part_o, rm_part_o, disp_len_o;
  logic [15:0] ea_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  modrm_decoder u_dut (
    .clk_i, .rst_ni, .valid_i, .opc_i, .modrm_i, .disp_lo_i, .disp_hi_i,
    .bx_i, .bp_i, .si_i, .di_i, .valid_o, .opcode_o, .reg_is_dst_o,
    .reg_idx_o, .reg_part_o, .rm_is_mem_o, .rm_idx_o, .rm_part_o,
    .disp_len_o, .ea_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of(input logic [2:0] rm, input logic [1:0] md,
      input logic [15:0] bx, input logic [15:0] bp, input logic [15:0] si, input logic [15:0] di);
    case (rm)
      3'd0: return bx + si;
      3'd1: return bx + di;
      3'd2: return bp + si;
      3'd3: return bp + di;
      3'd4: return si;
      3'd5: return di;
      3'd6: return (md == 2'b00) ? 16'h0 : bp;
      default: return bx;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] e_ea;
    logic [1:0]  e_len;
    int k;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "valid", valid_o, 0);
    chk("R1", "ea", ea_o, 0);
    chk("R1", "reg_part", reg_part_o, 0);
    chk("R1", "disp_len", disp_len_o, 0);
    chk("R1", "mem", rm_is_mem_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2", "idle valid", valid_o, 0);

    k = 0;
    for (int op = 0; op < 4; op++) begin
      for (int m = 0; m < 256; m++) begin
        logic w, d;
        logic [1:0] md;
        logic [2:0] rg, rm;
        k++;
        opc_i     = {6'(k * 7 + 13), 2'(op)};
        modrm_i   = 8'(m);
        disp_lo_i = 8'(k * 37 + 128);
        disp_hi_i = 8'(k * 11 + 200);
        bx_i      = 16'(k * 16'h1357 + 16'hF00F);
        bp_i      = 16'(k * 16'h2b1d + 16'hFF80);
        si_i      = 16'(k * 16'h0761 + 16'h8000);
        di_i      = 16'(k * 16'h3e05 + 16'hFFFE);
        valid_i   = 1'b1;
        w = op[0]; d = op[1];
        md = modrm_i[7:6]; rg = modrm_i[5:3]; rm = modrm_i[2:0];
        @(negedge clk_i);
        chk("R2", "valid", valid_o, 1);
        chk("R3", "opcode", opcode_o, opc_i[7:2]);
        chk("R4", "dst", reg_is_dst_o, d);
        if (w) begin
          chk("R5", "reg idx", reg_idx_o, rg);
          chk("R5", "reg part", reg_part_o, 3);
        end else begin
          chk("R6", "reg idx", reg_idx_o, rg % 4);
          chk("R6", "reg part", reg_part_o, (rg >= 4) ? 2 : 1);
        end
        if (md == 2'b11) begin
          chk("R7", "mem", rm_is_mem_o, 0);
          chk("R7", "rm idx", rm_idx_o, w ? rm : rm % 4);
          chk("R7", "rm part", rm_part_o, w ? 3 : ((rm >= 4) ? 2 : 1));
          chk("R7", "len", disp_len_o, 0);
          chk("R7", "ea", ea_o, 0);
        end else begin
          chk("R8", "mem", rm_is_mem_o, 1);
          chk("R8", "rm idx", rm_idx_o, 0);
          chk("R8", "rm part", rm_part_o, 0);
          e_len = (md == 2'b01) ? 2'd1 : (md == 2'b10) ? 2'd2 : (rm == 3'd6) ? 2'd2 : 2'd0;
          chk("R9", "len", disp_len_o, e_len);
          e_ea = base_of(rm, md, bx_i, bp_i, si_i, di_i);
          if (md == 2'b01)
            e_ea = e_ea + ((disp_lo_i >= 8'd128) ? 16'(int'(disp_lo_i) - 256) : 16'(disp_lo_i));
          else if (md == 2'b10 || rm == 3'd6)
            e_ea = e_ea + (16'(disp_hi_i) * 16'd256 + 16'(disp_lo_i));
          if (md == 2'b00 && rm == 3'd6)
            chk("R12", "direct ea", ea_o, e_ea);
          else if (md == 2'b00)
            chk("R10", "ea", ea_o, e_ea);
          else
            chk("R11", "ea", ea_o, e_ea);
        end
      end
    end

    // R2 hold: everything changes while valid is low
    begin
      logic [15:0] ea_q;
      logic [1:0]  lp, rp;
      logic        mem_q;
      ea_q = ea_o; lp = disp_len_o; rp = reg_part_o; mem_q = rm_is_mem_o;
      valid_i = 1'b0;
      modrm_i = 8'hC5; opc_i = 8'h00;
      bx_i = 16'h1111; bp_i = 16'h2222; si_i = 16'h3333; di_i = 16'h4444;
      repeat (2) @(negedge clk_i);
      chk("R2", "hold valid", valid_o, 0);
      chk("R2", "hold ea", ea_o, ea_q);
      chk("R2", "hold len", disp_len_o, lp);
      chk("R2", "hold reg part", reg_part_o, rp);
      chk("R2", "hold mem", rm_is_mem_o, mem_q);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule